// File: doc/BRIEF.md
# Packed Lane Integer Add, Subtract and Compare Unit

This unit treats each of two 64-bit operands as a row of independent packed lanes and applies one integer operation to every lane at once. At run time the request chooses the lane width (eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes). The operation is add, subtract, equality compare or signed greater-than compare. For add and subtract the request also chooses how overflow is handled: the lane wraps, clamps to its signed range, or clamps to its unsigned range. A carry or borrow never crosses from one lane into the next.

A compare produces a lane mask. Every lane of the 64-bit result is all ones where the condition holds and all zeros where it does not, so the mask can drive later select or blend logic directly. Requests are qualified by a valid strobe and the unit accepts one on every cycle. The result, an error flag and a valid strobe come out of a register two cycles after the request is sampled. Encodings the unit does not support return zero with the error flag set.

Top module: `simd_lane_alu`

## Requirements
- R1: The lane size code selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes and 2 gives two 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R2: With op code 0 (add) or 1 (subtract) and overflow mode 0, each lane result is the sum or difference modulo 2^W. No carry or borrow crosses a lane boundary.
- R3: With overflow mode 1, a signed overflow in a lane clamps that lane to 2^(W-1)-1 when the true result is positive and to -2^(W-1) when it is negative.
- R4: With overflow mode 2, an add lane with a carry out clamps to 2^W-1, and a subtract lane with a borrow clamps to 0.
- R5: Op code 2 compares lanes for equality and op code 3 compares for signed a greater than b. Each result lane is all ones when the condition holds and all zeros when it does not.
- R6: The overflow mode field, including code 3, has no effect on compare operations.
- R7: An op code from 4 to 7, a lane size code of 3, or an add or subtract with overflow mode 3 returns a zero result with the error flag set. Legal requests return with the error flag clear.
- R8: A request sampled with valid high at clock edge t gives a result with valid high after edge t+2, and at no other time. During reset the valid, error and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Op code: 0 add, 1 sub, 2 equal, 3 signed greater |
| req_size_i | input | 2 | Lane size code |
| req_sat_i | input | 2 | Overflow mode: 0 wrap, 1 signed clamp, 2 unsigned clamp |
| req_a_i | input | 64 | Operand a (minuend for subtract) |
| req_b_i | input | 64 | Operand b |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 64 | Packed lane result |
| res_err_o | output | 1 | Unsupported encoding flag |

## Verification
The assertions check several things on every cycle. Each request strobe produces exactly one result strobe two edges later. An error result always carries zero data. A bad lane size code always raises the error flag. Every compare result is made of whole lanes that are all ones or all zeros. Lane arithmetic can only be shown by the bench's scenarios. These cover the clamp values, wrap-around, the cut carries at lane boundaries, the signed versus unsigned clamp directions and compare outcomes. The bench compares them against its own per-lane model, across boundary operand values in every width, op code and mode.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned NSIZES = 3;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CEQ = 3'd2;
  localparam logic [2:0] OP_CGT = 3'd3;

  typedef enum logic [1:0] {SAT_WRAP = 2'd0, SAT_SGN = 2'd1, SAT_UNS = 2'd2, SAT_BAD = 2'd3} sat_e;

  typedef struct packed {
    logic [2:0]      op;
    logic [1:0]      size;
    logic [1:0]      sat;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
  } req_t;
endpackage

// File: rtl/lane_unit.sv
module lane_unit
  import simd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic [1:0]   sat_i,
  output logic [W-1:0] arith_o,
  output logic         eq_o,
  output logic         gt_o
);
  logic [W:0]   sum;
  logic         uovf, sovf;
  logic [W-1:0] smax, smin;

  assign smax = {1'b0, {(W-1){1'b1}}};
  assign smin = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    sum  = {1'b0, a_i} + {1'b0, b_i ^ {W{sub_i}}} + {{W{1'b0}}, sub_i};
    // carry out on add, missing carry (borrow) on sub
    uovf = sub_i ? ~sum[W] : sum[W];
    sovf = ((a_i[W-1] ^ b_i[W-1]) == sub_i) && (sum[W-1] != a_i[W-1]);
    unique case (sat_e'(sat_i))
      SAT_SGN: arith_o = sovf ? (a_i[W-1] ? smin : smax) : sum[W-1:0];
      SAT_UNS: arith_o = uovf ? (sub_i ? '0 : '1) : sum[W-1:0];
      default: arith_o = sum[W-1:0];
    endcase
  end

  assign eq_o = (a_i == b_i);
  assign gt_o = $signed(a_i) > $signed(b_i);
endmodule

// File: rtl/lane_array.sv
module lane_array
  import simd_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned N = XLEN
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  input  logic         gt_sel_i,
  input  logic [1:0]   sat_i,
  output logic [N-1:0] arith_o,
  output logic [N-1:0] mask_o
);
  localparam int unsigned NL = N / W;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic eq, gt;
    lane_unit #(.W(W)) u_lane (
      .a_i    (a_i[l*W +: W]),
      .b_i    (b_i[l*W +: W]),
      .sub_i  (sub_i),
      .sat_i  (sat_i),
      .arith_o(arith_o[l*W +: W]),
      .eq_o   (eq),
      .gt_o   (gt)
    );
    assign mask_o[l*W +: W] = {W{gt_sel_i ? gt : eq}};
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [2:0]      req_op_i,
  input  logic [1:0]      req_size_i,
  input  logic [1:0]      req_sat_i,
  input  logic [XLEN-1:0] req_a_i,
  input  logic [XLEN-1:0] req_b_i,
  output logic            res_valid_o,
  output logic [XLEN-1:0] res_data_o,
  output logic            res_err_o
);
  req_t            s1_q;
  logic            s1_valid_q;
  logic            s1_cmp, s1_bad;
  logic [XLEN-1:0] arith_w [NSIZES];
  logic [XLEN-1:0] mask_w  [NSIZES];
  logic [XLEN-1:0] s2_data;

  // stage 1: capture request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_q       <= '0;
    end else begin
      s1_valid_q <= req_valid_i;
      if (req_valid_i) s1_q <= '{op: req_op_i, size: req_size_i, sat: req_sat_i,
                                 a: req_a_i, b: req_b_i};
    end
  end

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    lane_array #(.W(8 << s), .N(XLEN)) u_arr (
      .a_i     (s1_q.a),
      .b_i     (s1_q.b),
      .sub_i   (s1_q.op == OP_SUB),
      .gt_sel_i(s1_q.op == OP_CGT),
      .sat_i   (s1_q.sat),
      .arith_o (arith_w[s]),
      .mask_o  (mask_w[s])
    );
  end

  always_comb begin
    s1_cmp = (s1_q.op == OP_CEQ) || (s1_q.op == OP_CGT);
    s1_bad = s1_q.op[2] || (s1_q.size == 2'd3) || (!s1_cmp && s1_q.sat == SAT_BAD);
    s2_data = '0;
    if (!s1_bad) s2_data = s1_cmp ? mask_w[s1_q.size] : arith_w[s1_q.size];
  end

  // stage 2: registered result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_err_o   <= 1'b0;
    end else begin
      res_valid_o <= s1_valid_q;
      if (s1_valid_q) begin
        res_data_o <= s2_data;
        res_err_o  <= s1_bad;
      end else begin
        res_err_o  <= 1'b0;
      end
    end
  end

  function automatic logic mask_ok(logic [XLEN-1:0] d, logic [1:0] sz);
    logic ok;
    int unsigned w;
    ok = 1'b1;
    w  = 8 << sz;
    for (int k = 0; k < XLEN; k++)
      if (d[k] != d[(k / w) * w]) ok = 1'b0;
    return ok;
  endfunction

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ##1 res_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ##1 !res_valid_o);
  a_r7_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_err_o |-> (res_valid_o && res_data_o == '0));
  a_r7_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd3) |=> ##1 res_err_o);
  a_r5_whole_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_cmp && !s1_bad) |=> mask_ok(res_data_o, $past(s1_q.size)));
endmodule

// File: tb/simd_lane_alu_tb_top.sv
module simd_lane_alu_tb_top;
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  size;
    logic [1:0]  sat;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 2'd0, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h0200_8000_0000_0030, 1'b0}, // R2 R1
    '{3'd0, 2'd0, 2'd1, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h0200_7F80_0000_0030, 1'b0}, // R3
    '{3'd0, 2'd0, 2'd2, 64'h01FF_7F80_0000_FF10, 64'h0101_0180_0000_0120, 64'h02FF_80FF_0000_FF30, 1'b0}, // R4
    '{3'd1, 2'd1, 2'd0, 64'h0000_8000_7FFF_0005, 64'h0001_0001_FFFF_0007, 64'hFFFF_7FFF_8000_FFFE, 1'b0}, // R2
    '{3'd1, 2'd1, 2'd1, 64'h0000_8000_7FFF_0005, 64'h0001_0001_FFFF_0007, 64'hFFFF_8000_7FFF_FFFE, 1'b0}, // R3
    '{3'd1, 2'd1, 2'd2, 64'h0000_8000_7FFF_0005, 64'h0001_0001_FFFF_0007, 64'h0000_7FFF_0000_0000, 1'b0}, // R4
    '{3'd0, 2'd2, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 64'h7FFF_FFFF_8000_0000, 1'b0}, // R3
    '{3'd0, 2'd2, 2'd0, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, 64'h8000_0000_7FFF_FFFF, 1'b0}, // R2
    '{3'd2, 2'd0, 2'd1, 64'h1122_3344_5566_7788, 64'h1100_3344_0066_7700, 64'hFF00_FFFF_00FF_FF00, 1'b0}, // R5 R6
    '{3'd3, 2'd1, 2'd2, 64'h8000_0001_7FFF_FFFF, 64'h7FFF_0000_8000_0000, 64'h0000_FFFF_FFFF_0000, 1'b0}, // R5 R6
    '{3'd3, 2'd2, 2'd0, 64'hFFFF_FFFF_0000_0002, 64'hFFFF_FFFE_0000_0002, 64'hFFFF_FFFF_0000_0000, 1'b0}, // R5
    '{3'd2, 2'd2, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R6
    '{3'd5, 2'd0, 2'd0, 64'h1, 64'h1, 64'h0, 1'b1},                                                     // R7
    '{3'd0, 2'd3, 2'd0, 64'h1, 64'h1, 64'h0, 1'b1},                                                     // R7
    '{3'd1, 2'd0, 2'd3, 64'h1, 64'h1, 64'h0, 1'b1}                                                      // R7
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_op_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [1:0]  req_sat_i = '0;
  logic [63:0] req_a_i = '0;
  logic [63:0] req_b_i = '0;
  logic        res_valid_o;
  logic [63:0] res_data_o;
  logic        res_err_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  simd_lane_alu dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_size_i(req_size_i), .req_sat_i(req_sat_i), .req_a_i(req_a_i), .req_b_i(req_b_i),
    .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_err_o(res_err_o)
  );

  task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_data(logic [2:0] op, logic [1:0] size, logic [1:0] sat,
                                           logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    int w;
    longint msk, ua, ub, sa, sb, v, hi, lo;
    r = '0;
    if (op > 3 || size == 3 || (op < 2 && sat == 3)) return r;
    w   = 8 << size;
    msk = (longint'(1) << w) - 1;
    hi  = (longint'(1) << (w - 1)) - 1;
    lo  = -(longint'(1) << (w - 1));
    for (int l = 0; l < 64 / w; l++) begin
      ua = longint'((a >> (l * w))) & msk;
      ub = longint'((b >> (l * w))) & msk;
      sa = (ua > hi) ? ua - msk - 1 : ua;
      sb = (ub > hi) ? ub - msk - 1 : ub;
      case (op)
        3'd2: v = (ua == ub) ? msk : 0;
        3'd3: v = (sa > sb) ? msk : 0;
        default: begin
          if (sat == 1) begin
            v = (op == 0) ? sa + sb : sa - sb;
            if (v > hi) v = hi;
            if (v < lo) v = lo;
          end else begin
            v = (op == 0) ? ua + ub : ua - ub;
            if (sat == 2) begin
              if (v > msk) v = msk;
              if (v < 0) v = 0;
            end
          end
        end
      endcase
      r = r | ((64'(v) & 64'(msk)) << (l * w));
    end
    return r;
  endfunction

  // drive at negedge, result sampled at negedge after second posedge
  task automatic run(logic [2:0] op, logic [1:0] size, logic [1:0] sat, logic [63:0] a,
                     logic [63:0] b, output logic [63:0] d, output logic e, output logic v);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_size_i = size; req_sat_i = sat;
    req_a_i = a; req_b_i = b;
    @(negedge clk);
    req_valid_i = 1'b0;
    @(negedge clk);
    d = res_data_o; e = res_err_o; v = res_valid_o;
  endtask

  initial begin
    logic [63:0] d;
    logic e, v;
    logic [63:0] bnd [4];
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset valid", 64'(res_valid_o), 64'd0);
    check("R8 reset data", res_data_o, 64'd0);
    check("R8 reset err", 64'(res_err_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8: latency, exactly one result strobe
    req_valid_i = 1'b1; req_op_i = 3'd0; req_size_i = 2'd0; req_sat_i = 2'd0;
    req_a_i = 64'h0101_0101_0101_0101; req_b_i = 64'h0202_0202_0202_0202;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R8 not yet valid", 64'(res_valid_o), 64'd0);
    @(negedge clk);
    check("R8 valid at t+2", 64'(res_valid_o), 64'd1);
    check("R8 data", res_data_o, 64'h0303_0303_0303_0303);
    @(negedge clk);
    check("R8 single strobe", 64'(res_valid_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].op, VECS[i].size, VECS[i].sat, VECS[i].a, VECS[i].b, d, e, v);
      check($sformatf("R1-vec%0d data (R2 R3 R4 R5 R6 R7)", i), d, VECS[i].exp);
      check($sformatf("R7 vec%0d err", i), 64'(e), 64'(VECS[i].err));
      check($sformatf("R8 vec%0d valid", i), 64'(v), 64'd1);
    end

    // boundary lane values in every width, op and mode
    for (int s = 0; s < 3; s++) begin
      int w;
      w = 8 << s;
      bnd[0] = 64'd0;
      bnd[1] = '0;
      bnd[2] = '0;
      bnd[3] = '1;
      for (int l = 0; l < 64 / w; l++) begin
        bnd[1] = bnd[1] | (((64'd1 << (w - 1)) - 1) << (l * w));
        bnd[2] = bnd[2] | ((64'd1 << (w - 1)) << (l * w));
      end
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int op = 0; op < 4; op++)
            for (int st = 0; st < 3; st++) begin
              run(3'(op), 2'(s), 2'(st), bnd[i], bnd[j], d, e, v);
              check("R1 R2 R3 R4 R5 boundary", d, ref_data(3'(op), 2'(s), 2'(st), bnd[i], bnd[j]));
            end
    end

    // random operands including unsupported codes
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      logic [1:0] sz, st;
      logic [63:0] a, b;
      op = 3'($urandom_range(0, 4));
      sz = 2'($urandom_range(0, 3));
      st = 2'($urandom_range(0, 3));
      a  = {$urandom, $urandom};
      b  = (i % 5 == 0) ? a : {$urandom, $urandom};
      run(op, sz, st, a, b, d, e, v);
      check("R2 R3 R4 R5 R6 random", d, ref_data(op, sz, st, a, b));
      check("R7 random err", 64'(e),
            64'(op > 3 || sz == 3 || (op < 2 && st == 3)));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule